// File: doc/BRIEF.md
# I2C SCL Clock Generator with Edge-Offset Strobes

This block makes the SCL waveform for an I2C master out of the core clock and gives the data path two timing strobes. A programmable divider sets the SCL period in core clocks. The least significant bit of the divider is dropped, so the period is always even. SCL spends exactly half of each period low and half high.

A launch strobe fires a programmable number of core clocks after each SCL falling edge. It marks the cycle in which the next SDA bit may be driven. A sample strobe fires a separate programmable number of core clocks after each SCL rising edge. It marks the cycle in which SDA is read. Both offsets are kept between 1 and half the period.

A hold request stretches the low phase just before SCL would rise. While the block is disabled, SCL rests high and no pulses appear. The bit and byte sequencing of the protocol is left to the logic that uses the strobes.

Top module: `i2c_scl_timer`

## Requirements
- R1: Out of reset, and in every cycle after a core clock edge that samples `en_i` low, `scl_o` is 1 and `scl_rise_o`, `scl_fall_o`, `launch_o` and `sample_o` are all 0.
- R2: Let H be `div_i` shifted right by one bit (bit 0 is ignored). Once running, SCL is low for H cycles and then high for H cycles, over and over. An odd divider therefore behaves like the next lower even value.
- R3: When H is 0 (divider 0 or 1), the divider acts as the largest even value (2^DIV_W − 2), so each phase lasts 2^(DIV_W−1) − 1 cycles.
- R4: `scl_fall_o` and `scl_rise_o` are single-cycle pulses. Each is high exactly in the first cycle of the new SCL level.
- R5: `launch_o` pulses once, F cycles after each falling-edge cycle, where F is the effective value of `fall_dly_i`. `sample_o` pulses once, R cycles after each rising-edge cycle, where R is the effective value of `rise_dly_i`.
- R6: A delay input of 0 is used as 1.
- R7: A delay above H is used as H. The launch strobe then lands in the same cycle as the rising-edge pulse, and the sample strobe lands in the same cycle as the falling-edge pulse.
- R8: If `hold_i` is high when SCL is low and the low phase has reached its last cycle, SCL stays low. The rising edge follows on the first clock edge that samples `hold_i` low. A launch strobe whose delay equals H is postponed so that it coincides with that rising edge, and it still fires only once.
- R9: `hold_i` has no effect while SCL is high.
- R10: Dropping `en_i` returns the outputs to the idle state of R1 in the next cycle, with no edge pulse. The first clock edge that samples `en_i` high after idle drives SCL low and raises `scl_fall_o`. No sample strobe appears before the first rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low forces idle |
| hold_i | input | 1 | Stretch request; extends the low phase at its end |
| div_i | input | DIV_W | Period in core clocks; bit 0 ignored |
| fall_dly_i | input | DLY_W | Launch offset after SCL falls |
| rise_dly_i | input | DLY_W | Sample offset after SCL rises |
| scl_o | output | 1 | SCL level |
| scl_rise_o | output | 1 | Pulse in the first high cycle |
| scl_fall_o | output | 1 | Pulse in the first low cycle |
| launch_o | output | 1 | Data launch strobe |
| sample_o | output | 1 | Data sample strobe |

## Verification
The risky overlap is a strobe and an edge pulse falling in the same cycle. This happens when a delay is clamped to or equals half the period, so that launch meets the rising edge or sample meets the falling edge. It also happens when a stretched low phase is released with the launch delay at its maximum. The bench provokes these cases with a two-cycle divider, delays of zero and delays far above the half period, and a hold held across the end of the low phase. It compares each cycle's full set of outputs against a cycle-indexed model, so a strobe that is lost, doubled or shifted by one cycle shows up as a mismatch in that exact cycle.

// File: rtl/i2c_scl_pkg.sv
`timescale 1ns/1ps
package i2c_scl_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } scl_phase_e;

  localparam int unsigned N_STROBE = 2;
  localparam int unsigned STB_LAUNCH = 0;
  localparam int unsigned STB_SAMPLE = 1;
endpackage

// File: rtl/scl_div_cfg.sv
`timescale 1ns/1ps
module scl_div_cfg #(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned DLY_W = 16,
  localparam int unsigned HW = DIV_W - 1
) (
  input  logic [DIV_W-1:0]   div_i,
  input  logic [DLY_W-1:0]   fall_dly_i,
  input  logic [DLY_W-1:0]   rise_dly_i,
  output logic [HW-1:0]      half_o,
  output logic [1:0][HW-1:0] dly_eff_o
);
  import i2c_scl_pkg::*;

  localparam int unsigned CW = (DLY_W > HW) ? DLY_W : HW;

  logic [DLY_W-1:0] dly_raw [N_STROBE];

  // LSB dropped; zero half maps to the largest even period
  assign half_o = (div_i[DIV_W-1:1] == '0) ? '1 : div_i[DIV_W-1:1];

  assign dly_raw[STB_LAUNCH] = fall_dly_i;
  assign dly_raw[STB_SAMPLE] = rise_dly_i;

  for (genvar g = 0; g < N_STROBE; g++) begin : g_clamp
    logic [CW-1:0] raw_x;
    logic [CW-1:0] half_x;
    assign raw_x  = CW'(dly_raw[g]);
    assign half_x = CW'(half_o);
    always_comb begin
      if (raw_x == '0)         dly_eff_o[g] = HW'(1);
      else if (raw_x > half_x) dly_eff_o[g] = half_o;
      else                     dly_eff_o[g] = HW'(raw_x);
    end
  end
endmodule

// File: rtl/scl_phase_gen.sv
`timescale 1ns/1ps
module scl_phase_gen #(
  parameter int unsigned HW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          hold_i,
  input  logic [HW-1:0] half_i,
  output logic          scl_o,
  output logic          rise_o,
  output logic          fall_o,
  output logic [HW-1:0] cnt_o,
  output logic          adv_o
);
  logic          run_q, scl_q, rise_q, fall_q;
  logic [HW-1:0] cnt_q;
  logic          last, stall;

  assign last  = (cnt_q >= half_i - HW'(1));
  assign stall = hold_i && !scl_q && last;
  assign adv_o = run_q && en_i && !stall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      scl_q  <= 1'b1;
      cnt_q  <= '0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else if (!en_i) begin
      run_q  <= 1'b0;
      scl_q  <= 1'b1;
      cnt_q  <= '0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else if (!run_q) begin
      // first enabled edge starts with SCL falling
      run_q  <= 1'b1;
      scl_q  <= 1'b0;
      cnt_q  <= '0;
      rise_q <= 1'b0;
      fall_q <= 1'b1;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if (!stall) begin
        if (last) begin
          scl_q  <= ~scl_q;
          cnt_q  <= '0;
          rise_q <= ~scl_q;
          fall_q <= scl_q;
        end else begin
          cnt_q <= cnt_q + HW'(1);
        end
      end
    end
  end

  assign scl_o  = scl_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/scl_strobe_gen.sv
`timescale 1ns/1ps
module scl_strobe_gen
  import i2c_scl_pkg::*;
#(
  parameter int unsigned HW    = 15,
  parameter scl_phase_e  LEVEL = PH_LOW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          level_i,
  input  logic [HW-1:0] cnt_i,
  input  logic [HW-1:0] dly_i,
  output logic          strobe_o
);
  logic strobe_q;

  // registered: visible dly_i cycles after the edge cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else         strobe_q <= adv_i && (level_i == logic'(LEVEL)) &&
                             (cnt_i == dly_i - HW'(1));
  end

  assign strobe_o = strobe_q;
endmodule

// File: rtl/i2c_scl_timer.sv
`timescale 1ns/1ps
module i2c_scl_timer #(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             hold_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [DLY_W-1:0] fall_dly_i,
  input  logic [DLY_W-1:0] rise_dly_i,
  output logic             scl_o,
  output logic             scl_rise_o,
  output logic             scl_fall_o,
  output logic             launch_o,
  output logic             sample_o
);
  import i2c_scl_pkg::*;

  localparam int unsigned HW = DIV_W - 1;

  logic [HW-1:0]         half;
  logic [1:0][HW-1:0]    dly_eff;
  logic [HW-1:0]         cnt;
  logic                  adv;
  logic                  scl;
  logic [N_STROBE-1:0]   strobe;

  scl_div_cfg #(.DIV_W(DIV_W), .DLY_W(DLY_W)) i_cfg (
    .div_i      (div_i),
    .fall_dly_i (fall_dly_i),
    .rise_dly_i (rise_dly_i),
    .half_o     (half),
    .dly_eff_o  (dly_eff)
  );

  scl_phase_gen #(.HW(HW)) i_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .hold_i (hold_i),
    .half_i (half),
    .scl_o  (scl),
    .rise_o (scl_rise_o),
    .fall_o (scl_fall_o),
    .cnt_o  (cnt),
    .adv_o  (adv)
  );

  for (genvar g = 0; g < N_STROBE; g++) begin : g_stb
    scl_strobe_gen #(
      .HW    (HW),
      .LEVEL ((g == STB_LAUNCH) ? PH_LOW : PH_HIGH)
    ) i_stb (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .adv_i    (adv),
      .level_i  (scl),
      .cnt_i    (cnt),
      .dly_i    (dly_eff[g]),
      .strobe_o (strobe[g])
    );
  end

  assign scl_o    = scl;
  assign launch_o = strobe[STB_LAUNCH];
  assign sample_o = strobe[STB_SAMPLE];
endmodule

// File: rtl/i2c_scl_timer_chk.sv
`timescale 1ns/1ps
module i2c_scl_timer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic hold_i,
  input logic scl_o,
  input logic scl_rise_o,
  input logic scl_fall_o,
  input logic launch_o,
  input logic sample_o
);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!en_i) |-> (scl_o && !scl_rise_o && !scl_fall_o && !launch_o && !sample_o));

  a_r4_rise_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_rise_o |-> (scl_o && !$past(scl_o)));

  a_r4_fall_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_fall_o |-> (!scl_o && $past(scl_o)));

  a_r4_edge_marked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && (scl_o != $past(scl_o))) |-> (scl_rise_o || scl_fall_o));

  a_r5_launch_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |-> (!scl_o || scl_rise_o));

  a_r5_sample_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> (scl_o || scl_fall_o));

  a_r8_hold_blocks_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(hold_i && !scl_o && en_i) |-> !scl_rise_o);
endmodule

bind i2c_scl_timer i2c_scl_timer_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .hold_i     (hold_i),
  .scl_o      (scl_o),
  .scl_rise_o (scl_rise_o),
  .scl_fall_o (scl_fall_o),
  .launch_o   (launch_o),
  .sample_o   (sample_o)
);

// File: tb/test_i2c_scl_timer.sv
`timescale 1ns/1ps
module test_i2c_scl_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        hold_i = 1'b0;
  logic [15:0] div_i = 16'd4;
  logic [15:0] fall_dly_i = 16'd1;
  logic [15:0] rise_dly_i = 16'd1;
  logic        scl_o, scl_rise_o, scl_fall_o, launch_o, sample_o;

  typedef struct {
    logic [4:0] v;   // {scl, rise, fall, launch, sample}
    string      tag;
  } item_t;

  item_t sb[$];
  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  i2c_scl_timer i_i2c_scl_timer (
    .clk_i, .rst_ni, .en_i, .hold_i, .div_i, .fall_dly_i, .rise_dly_i,
    .scl_o, .scl_rise_o, .scl_fall_o, .launch_o, .sample_o
  );

  // k: cycles since the enabling edge; h half period; fe/re effective delays
  function automatic logic [4:0] model(int k, int h, int fe, int re);
    int p;
    logic s, r, f, l, m;
    p = k % (2 * h);
    s = (p >= h);
    r = (p == h);
    f = (p == 0);
    l = (k >= fe) && (((k - fe) % (2 * h)) == 0);
    m = (k >= h + re) && (((k - h - re) % (2 * h)) == 0);
    return {s, r, f, l, m};
  endfunction

  task automatic push_run(int h, int fe, int re, int k0, int k1, string tag);
    for (int k = k0; k <= k1; k++) begin
      item_t it;
      it.v = model(k, h, fe, re);
      it.tag = tag;
      sb.push_back(it);
    end
  endtask

  task automatic push_vec(logic [4:0] v, int n, string tag);
    for (int i = 0; i < n; i++) begin
      item_t it;
      it.v = v;
      it.tag = tag;
      sb.push_back(it);
    end
  endtask

  task automatic drain();
    wait (sb.size() == 0);
    @(negedge clk_i);
  endtask

  task automatic go_idle(string tag);
    en_i = 1'b0;
    hold_i = 1'b0;
    push_vec(5'b10000, 3, tag);
    drain();
  endtask

  task automatic run_cfg(int dv, int fd, int rd, int h, int fe, int re, int n, string tag);
    div_i = 16'(dv);
    fall_dly_i = 16'(fd);
    rise_dly_i = 16'(rd);
    en_i = 1'b1;
    push_run(h, fe, re, 0, n - 1, tag);
    drain();
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (sb.size() > 0) begin
        item_t it;
        logic [4:0] got;
        it = sb.pop_front();
        got = {scl_o, scl_rise_o, scl_fall_o, launch_o, sample_o};
        n_run++;
        if (got !== it.v) begin
          n_fail++;
          $display("FAIL %s: got {scl,rise,fall,launch,sample}=%b expected %b at %0t",
                   it.tag, got, it.v, $time);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  // driver
  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    push_vec(5'b10000, 3, "R1");
    drain();

    // R2 R4 R5: div 10 -> half 5, launch 2, sample 3
    run_cfg(10, 2, 3, 5, 2, 3, 43, "R2/R4/R5");
    go_idle("R10");

    // R2: odd divider 7 behaves as 6
    run_cfg(7, 1, 1, 3, 1, 1, 25, "R2");
    go_idle("R10");

    // R6: zero delays act as 1, smallest divider
    run_cfg(2, 0, 0, 1, 1, 1, 12, "R6");
    go_idle("R10");

    // R7: delays above half are clamped, strobes meet edges
    run_cfg(12, 100, 9, 6, 6, 6, 38, "R7");
    go_idle("R10");

    // R8 R9: stretch with launch delay equal to half (div 8 -> half 4)
    div_i = 16'd8;
    fall_dly_i = 16'd4;
    rise_dly_i = 16'd1;
    hold_i = 1'b1;
    en_i = 1'b1;
    push_vec(5'b00100, 1, "R8");
    push_vec(5'b00000, 9, "R8");
    drain();
    hold_i = 1'b0;
    push_run(4, 4, 1, 4, 4, "R8");
    push_run(4, 4, 1, 5, 9, "R9");
    push_run(4, 4, 1, 10, 27, "R8");
    @(negedge clk_i);
    hold_i = 1'b1;          // asserted only while SCL is high
    repeat (4) @(negedge clk_i);
    hold_i = 1'b0;
    drain();
    go_idle("R10");

    // R3: divider 0 -> largest even period, half 32767
    run_cfg(0, 1, 1, 32767, 1, 1, 65537, "R3");
    go_idle("R10");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule